// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block sits between the external interrupt pins of a processor and its interrupt logic. It resynchronises a non-maskable interrupt (NMI) pin and a group of active-low request pins to the bus clock. From the NMI pin it forms an edge-triggered pending request. From the request pins it forms either one encoded priority level or a set of independent level requests. The encoded level is only accepted once it has been stable for several samples.

A small control register is written through a 32-bit write port, and three of its bits steer the block. The pin-mode bit picks encoded or independent requests. The NMI pass bit decides whether a pending NMI is held back while the CPU's block flag is high. The NMI edge bit picks the falling or the rising pin edge. An acknowledge input clears the pending NMI. When an NMI is let through while the block flag is high, a one-cycle status pulse warns that saved exception context is about to be overwritten.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset all three control fields are 0, and nmi_req, nmi_ctx_lost, irq_valid and irq_code are all 0.
- R2: A cycle with cfg_we high loads cfg_wdata bit 25 as the pin-mode field, bit 24 as the NMI pass field and bit 23 as the NMI edge field. All other bits of cfg_wdata have no effect.
- R3: With the edge field at 0, a high-to-low change of nmi_pin sets the pending NMI. With the edge field at 1, a low-to-high change sets it. If the pin changes before rising clock edge k, nmi_req is high after edge k+2 (provided it is not held back, R4). The opposite edge sets nothing.
- R4: With the pass field at 0, nmi_req stays low while cpu_block is 1 and the NMI is pending. nmi_req goes high in the same cycle that cpu_block returns to 0.
- R5: With the pass field at 1, a pending NMI drives nmi_req regardless of cpu_block. In the first cycle that the NMI is pending, nmi_ctx_lost is high for exactly that cycle if cpu_block is 1 and the pass field is 1.
- R6: nmi_ack high at a clock edge clears the pending NMI after that edge. If a new edge is detected at the same clock edge, the request stays pending.
- R7: With pin-mode 0, req_pin_n is active low and read as one 4-bit word. A word is accepted after four consecutive identical synchronised samples; if it is held from before edge k, it is accepted after edge k+6. An accepted word of 4'hF gives irq_valid 0 and irq_code 0. Any other accepted word gives irq_valid 1 and irq_code equal to the bitwise inverse of the word.
- R8: In pin-mode 0, a word held for fewer than four samples is never accepted, and the previously accepted word stays on the outputs.
- R9: With pin-mode 1, each low pin is its own request with no filtering. irq_valid is high when any pin is low. irq_code is the index of the lowest-numbered low pin, or 0 when none is low. A pin change before edge k shows after edge k+1.
- R10: A write that changes the pin-mode field discards the accepted encoded word (treated as 4'hF) and restarts the stability count. For pins held constant, the word is accepted again after edge m+4, where m is the write edge.
- R11: nmi_ack has no effect on irq_valid or irq_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| nmi_pin | input | 1 | Asynchronous NMI pin |
| req_pin_n | input | 4 | Asynchronous active-low request pins |
| cpu_block | input | 1 | CPU block flag |
| nmi_ack | input | 1 | Clears the pending NMI |
| nmi_req | output | 1 | NMI request to the CPU |
| nmi_ctx_lost | output | 1 | Pulse: NMI let through while blocked |
| irq_valid | output | 1 | A maskable request is present |
| irq_code | output | 4 | Encoded level or index of the independent request |

## Verification
Each result has its own delay from the pin. An NMI edge reaches nmi_req two edges after it is first sampled, an independent request one edge after, and an encoded word six edges after. After a pin-mode write, the encoded word is accepted again four edges after the write. The bench keeps a history of the pin values it has driven and a counter of edges since the last filter clear. It derives each expected output from the history entries at exactly those distances. Inputs change on falling edges, and every output is compared one nanosecond after each rising edge, so each check sees the cycle in which the result is due.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

   // Bit positions of the control fields inside the written word
   localparam int CFG_MODE_BIT = 25;
   localparam int CFG_PASS_BIT = 24;
   localparam int CFG_EDGE_BIT = 23;

   typedef struct packed {
      logic pin_mode;   // 0: encoded word, 1: independent lines
      logic nmi_pass;   // 1: NMI not held back by the block flag
      logic nmi_rise;   // 1: rising edge, 0: falling edge
   } irq_cfg_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irq_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("irq_sync: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/nmi_edge_unit.sv
module nmi_edge_unit (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic rise_sel,
   input  logic pass,
   input  logic cpu_block,
   input  logic ack,
   output logic edge_o,
   output logic pend_o,
   output logic req_o,
   output logic ctx_lost_o
);

   logic prev_q;
   logic pend_q;
   logic fresh_q;

   // edge of the synchronised pin against its previous sample
   assign edge_o = rise_sel ? (pin_s & ~prev_q) : (~pin_s & prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b1;
         pend_q  <= 1'b0;
         fresh_q <= 1'b0;
      end else begin
         prev_q  <= pin_s;
         pend_q  <= edge_o | (pend_q & ~ack);
         fresh_q <= edge_o & ~pend_q;
      end
   end

   assign pend_o     = pend_q;
   assign req_o      = pend_q & (~cpu_block | pass);
   assign ctx_lost_o = fresh_q & cpu_block & pass;

endmodule

// File: rtl/level_filter.sv
module level_filter #(
   parameter int W      = 4,
   parameter int STABLE = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] samp,
   output logic [W-1:0] filt_o
);

   localparam int             RUN_W   = (STABLE > 2) ? $clog2(STABLE) : 1;
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(STABLE - 1);

   generate
      if (STABLE < 2) begin : g_bad_stable
         $error("level_filter: STABLE must be at least 2");
      end
   endgenerate

   logic [W-1:0]     last_q;
   logic [W-1:0]     filt_q;
   logic [RUN_W-1:0] run_q;
   logic             same;

   assign same = (samp == last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= '1;
         filt_q <= '1;
         run_q  <= '0;
      end else begin
         last_q <= samp;
         if (clr) begin
            filt_q <= '1;
            run_q  <= '0;
         end else begin
            if (run_q == RUN_MAX) filt_q <= last_q;
            if (!same)                run_q <= '0;
            else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
         end
      end
   end

   assign filt_o = filt_q;

endmodule

// File: rtl/req_encoder.sv
module req_encoder #(
   parameter int W = 4
) (
   input  logic         indep,
   input  logic [W-1:0] filt_n,
   input  logic [W-1:0] live_n,
   output logic         valid,
   output logic [W-1:0] code
);

   localparam int CODE_W = $clog2(W);

   generate
      if (W < 2) begin : g_bad_w
         $error("req_encoder: W must be at least 2");
      end
   endgenerate

   logic [W-1:0]      act;
   logic [CODE_W-1:0] idx;
   logic              any_act;

   assign act     = ~live_n;
   assign any_act = |act;

   // lowest-numbered active line wins
   always_comb begin
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (act[i]) idx = CODE_W'(i);
      end
   end

   always_comb begin
      if (indep) begin
         valid = any_act;
         code  = {{(W - CODE_W){1'b0}}, idx};
      end else begin
         valid = (filt_n != '1);
         code  = ~filt_n;
      end
   end

endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
   import ext_irq_pkg::*;
#(
   parameter int NREQ           = 4,
   parameter int SYNC_STAGES    = 2,
   parameter int STABLE_SAMPLES = 4,
   parameter int CFG_W          = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             nmi_pin,
   input  logic [NREQ-1:0]  req_pin_n,
   input  logic             cpu_block,
   input  logic             nmi_ack,
   output logic             nmi_req,
   output logic             nmi_ctx_lost,
   output logic             irq_valid,
   output logic [NREQ-1:0]  irq_code
);

   generate
      if (CFG_W < CFG_MODE_BIT + 2) begin : g_bad_cfg_w
         $error("ext_irq_cond: CFG_W too narrow for the control fields");
      end
      if (NREQ < 2) begin : g_bad_nreq
         $error("ext_irq_cond: NREQ must be at least 2");
      end
   endgenerate

   // control register
   irq_cfg_t cfg_q;
   irq_cfg_t cfg_d;
   logic     mode_clr;
   logic     unused_cfg_bits;

   always_comb begin
      cfg_d.pin_mode = cfg_wdata[CFG_MODE_BIT];
      cfg_d.nmi_pass = cfg_wdata[CFG_PASS_BIT];
      cfg_d.nmi_rise = cfg_wdata[CFG_EDGE_BIT];
   end

   assign unused_cfg_bits = ^{cfg_wdata[CFG_W-1:CFG_MODE_BIT+1],
                              cfg_wdata[CFG_EDGE_BIT-1:0]};

   assign mode_clr = cfg_we && (cfg_d.pin_mode != cfg_q.pin_mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_we) cfg_q <= cfg_d;
   end

   // pin synchronisers
   logic            nmi_s;
   logic [NREQ-1:0] req_s;

   irq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_nmi_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (nmi_pin),
      .q     (nmi_s)
   );

   irq_sync #(.W(NREQ), .STAGES(SYNC_STAGES), .RST_VAL({NREQ{1'b1}})) u_req_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (req_pin_n),
      .q     (req_s)
   );

   // NMI path
   logic nmi_edge;
   logic nmi_pend;

   nmi_edge_unit u_nmi (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_s      (nmi_s),
      .rise_sel   (cfg_q.nmi_rise),
      .pass       (cfg_q.nmi_pass),
      .cpu_block  (cpu_block),
      .ack        (nmi_ack),
      .edge_o     (nmi_edge),
      .pend_o     (nmi_pend),
      .req_o      (nmi_req),
      .ctx_lost_o (nmi_ctx_lost)
   );

   // maskable request path
   logic [NREQ-1:0] req_filt;

   level_filter #(.W(NREQ), .STABLE(STABLE_SAMPLES)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (mode_clr),
      .samp   (req_s),
      .filt_o (req_filt)
   );

   req_encoder #(.W(NREQ)) u_enc (
      .indep  (cfg_q.pin_mode),
      .filt_n (req_filt),
      .live_n (req_s),
      .valid  (irq_valid),
      .code   (irq_code)
   );

endmodule

// File: rtl/ext_irq_cond_chk.sv
module ext_irq_cond_chk
   import ext_irq_pkg::*;
#(
   parameter int NREQ = 4
) (
   input logic            clk,
   input logic            rst_n,
   input irq_cfg_t        cfg,
   input logic            cpu_block,
   input logic            nmi_ack,
   input logic            nmi_edge,
   input logic            nmi_pend,
   input logic            nmi_req,
   input logic            nmi_ctx_lost,
   input logic            irq_valid,
   input logic [NREQ-1:0] irq_code
);

   // R3
   edge_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_edge |=> nmi_pend);

   // R4
   blocked_nmi_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg.nmi_pass && cpu_block) |-> !nmi_req);

   // R5
   ctx_lost_context_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_ctx_lost |-> (nmi_req && cpu_block));

   // R5
   ctx_lost_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_ctx_lost |=> !nmi_ctx_lost);

   // R6
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_ack && !nmi_edge) |=> !nmi_pend);

   // R9
   indep_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.pin_mode && irq_valid) |-> (irq_code < NREQ));

   // R10
   mode_switch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(cfg.pin_mode) && !cfg.pin_mode) |-> !irq_valid);

endmodule

bind ext_irq_cond ext_irq_cond_chk #(.NREQ(NREQ)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg          (cfg_q),
   .cpu_block    (cpu_block),
   .nmi_ack      (nmi_ack),
   .nmi_edge     (nmi_edge),
   .nmi_pend     (nmi_pend),
   .nmi_req      (nmi_req),
   .nmi_ctx_lost (nmi_ctx_lost),
   .irq_valid    (irq_valid),
   .irq_code     (irq_code)
);

// File: tb/ext_irq_cond_test.sv
`timescale 1ns/1ps
module ext_irq_cond_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        nmi_pin = 1'b1;
   logic [3:0]  req_pin_n = 4'hF;
   logic        cpu_block = 1'b0;
   logic        nmi_ack = 1'b0;
   logic        nmi_req;
   logic        nmi_ctx_lost;
   logic        irq_valid;
   logic [3:0]  irq_code;

   int    vectors = 0;
   int    miscompares = 0;
   bit    running = 0;
   bit    done = 0;
   string phase = "R1";

   always #2.5 clk = ~clk;

   ext_irq_cond uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_wdata    (cfg_wdata),
      .nmi_pin      (nmi_pin),
      .req_pin_n    (req_pin_n),
      .cpu_block    (cpu_block),
      .nmi_ack      (nmi_ack),
      .nmi_req      (nmi_req),
      .nmi_ctx_lost (nmi_ctx_lost),
      .irq_valid    (irq_valid),
      .irq_code     (irq_code)
   );

   // reference model: history of driven pins, index 0 = latest sample
   bit       nh [4];
   bit [3:0] rh [7];
   bit       m_pend, m_fresh, m_mode, m_pass, m_rise;
   bit [3:0] m_filt;
   int       since;

   task automatic model_reset();
      for (int i = 0; i < 4; i++) nh[i] = 1'b1;
      for (int i = 0; i < 7; i++) rh[i] = 4'hF;
      m_pend = 0; m_fresh = 0; m_mode = 0; m_pass = 0; m_rise = 0;
      m_filt = 4'hF; since = 0;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         bit e;
         for (int i = 3; i > 0; i--) nh[i] = nh[i-1];
         nh[0] = nmi_pin;
         for (int i = 6; i > 0; i--) rh[i] = rh[i-1];
         rh[0] = req_pin_n;
         e = m_rise ? (!nh[3] && nh[2]) : (nh[3] && !nh[2]);
         m_fresh = e && !m_pend;
         m_pend  = e || (m_pend && !nmi_ack);
         if (cfg_we && (cfg_wdata[25] != m_mode)) begin
            m_filt = 4'hF;
            since  = 0;
         end else begin
            if (since >= 3 && rh[3] == rh[4] && rh[4] == rh[5] && rh[5] == rh[6])
               m_filt = rh[3];
            if (since < 1000) since++;
         end
         if (cfg_we) begin
            m_mode = cfg_wdata[25];
            m_pass = cfg_wdata[24];
            m_rise = cfg_wdata[23];
         end
      end
   end

   task automatic chk(string tag, string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // compare every cycle, 1 ns after the rising edge
   always @(posedge clk) begin
      #1;
      if (running) begin
         bit       e_req, e_ctx, e_val;
         bit [3:0] e_code;
         e_req = m_pend && (!cpu_block || m_pass);
         e_ctx = m_fresh && cpu_block && m_pass;
         if (!m_mode) begin
            e_val  = (m_filt != 4'hF);
            e_code = ~m_filt;
         end else begin
            e_val  = (rh[1] != 4'hF);
            e_code = 4'd0;
            for (int i = 3; i >= 0; i--) if (!rh[1][i]) e_code = 4'(i);
         end
         chk(phase, "nmi_req", int'(nmi_req), int'(e_req));
         chk(phase, "nmi_ctx_lost", int'(nmi_ctx_lost), int'(e_ctx));
         chk(phase, "irq_valid", int'(irq_valid), int'(e_val));
         chk(phase, "irq_code", int'(irq_code), int'(e_code));
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wcfg(bit mode, bit pass, bit rise, logic [31:0] junk);
      cfg_wdata = (junk & ~32'h0380_0000) | {6'd0, mode, pass, rise, 23'd0};
      cfg_we = 1'b1;
      tick(1);
      cfg_we = 1'b0;
      cfg_wdata = '0;
   endtask

   task automatic ack_pulse();
      nmi_ack = 1'b1;
      tick(1);
      nmi_ack = 1'b0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      #100000;
      if (!done) begin
         miscompares++;
         $display("FAIL R1 watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      tick(3);
      // R1: reset values seen at the ports
      chk("R1", "nmi_req", int'(nmi_req), 0);
      chk("R1", "nmi_ctx_lost", int'(nmi_ctx_lost), 0);
      chk("R1", "irq_valid", int'(irq_valid), 0);
      chk("R1", "irq_code", int'(irq_code), 0);
      rst_n = 1'b1;
      running = 1;
      tick(5);

      phase = "R3";            // falling edge, default select
      nmi_pin = 1'b0; tick(6);
      phase = "R6";
      ack_pulse(); tick(2);
      phase = "R3";
      nmi_pin = 1'b1; tick(5);  // rising edge ignored under falling select
      wcfg(0, 0, 1, 32'h0);     // rising select
      nmi_pin = 1'b0; tick(5);  // falling now ignored
      nmi_pin = 1'b1; tick(6);
      ack_pulse(); tick(2);

      phase = "R4";            // held while blocked
      cpu_block = 1'b1;
      nmi_pin = 1'b0; tick(3);
      nmi_pin = 1'b1; tick(6);
      cpu_block = 1'b0; tick(3);
      ack_pulse(); tick(2);

      phase = "R5";            // let through while blocked
      wcfg(0, 1, 1, 32'h0);
      cpu_block = 1'b1;
      nmi_pin = 1'b0; tick(3);
      nmi_pin = 1'b1; tick(6);
      ack_pulse(); tick(1);
      cpu_block = 1'b0; tick(2);

      phase = "R6";            // ack overlapping a fresh edge
      nmi_pin = 1'b0; tick(2);
      nmi_ack = 1'b1;
      nmi_pin = 1'b1; tick(5);
      nmi_ack = 1'b0; tick(3);
      ack_pulse(); tick(2);

      phase = "R2";            // junk bits around the fields
      wcfg(0, 0, 0, 32'hFFFF_FFFF);
      nmi_pin = 1'b0; tick(5);
      ack_pulse();
      nmi_pin = 1'b1; tick(4);

      phase = "R7";
      req_pin_n = 4'b1010; tick(10);
      req_pin_n = 4'b0011; tick(10);

      phase = "R8";
      req_pin_n = 4'b0110; tick(2);
      req_pin_n = 4'b0011; tick(8);
      req_pin_n = 4'b1100; tick(3);
      req_pin_n = 4'b0011; tick(8);

      phase = "R11";
      nmi_ack = 1'b1; tick(3);
      nmi_ack = 1'b0; tick(2);

      phase = "R9";
      wcfg(1, 0, 0, 32'h0);
      req_pin_n = 4'b1111; tick(3);
      req_pin_n = 4'b0110; tick(3);
      req_pin_n = 4'b0101; tick(3);
      req_pin_n = 4'b0111; tick(3);
      req_pin_n = 4'b1011; tick(3);
      req_pin_n = 4'b1111; tick(3);

      phase = "R10";
      req_pin_n = 4'b0101; tick(4);
      wcfg(0, 0, 0, 32'h0); tick(8);
      wcfg(1, 0, 0, 32'h0); tick(2);
      wcfg(0, 0, 0, 32'h0); tick(8);
      wcfg(0, 0, 0, 32'h0); tick(3);   // same mode rewritten: no clear
      req_pin_n = 4'hF; tick(10);

      running = 0;
      done = 1;
      finish_run();
   end

endmodule